// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM Core

This block is a synchronous memory with a read port and a write port that work independently and may both issue a request in the same cycle. Both ports share one address input. The block models a double-edge interface with one clock that runs at twice the data rate, so each `clk_i` cycle carries one data beat. Every transfer is a fixed burst of four beats.

Each storage word is four beats wide, so `addr_i` names a whole burst and is two bits narrower than a beat-granular address would be. On the write side, a collector gathers the four incoming beats and their per-beat lane enables, then commits them to the array in a single access. On the read side, the block fetches one full word and streams it out one beat per cycle through a registered output stage, with a valid flag. A mode input adds one stage to that output path, which models the output register being timed by a separate output clock rather than by the input clock.

Reads and writes stay coherent with each other. A read returns every write that was accepted in the same cycle as the read or earlier, even when that write's beats are still arriving. It returns none of the writes accepted after the read.

Top module: `qdr_b4_core`

## Requirements
- R1: A write sends its beats on `din_i` in four consecutive cycles, starting with the cycle of the accepted request. A read returns its beats on `dout_o` in four consecutive cycles in linear order, beat 0 first. Beat k of a word occupies bits k*DW to k*DW+DW-1 of the storage word.
- R2: With `oreg_sep_i`=0, beat 0 of a read appears on `dout_o` just after the 5th rising edge that follows the edge accepting the read. With `oreg_sep_i`=1 it appears one cycle later.
- R3: `dvalid_o` is high exactly during the four beats of each accepted read. Two reads accepted four cycles apart give eight high cycles in a row. While `dvalid_o` is low, `dout_o` is all zeros.
- R4: `be_i` is sampled with each beat. Bit k enables bits k*BYTE_W to k*BYTE_W+BYTE_W-1 of that beat. A lane whose enable is low keeps its stored value.
- R5: `addr_i` selects one of 2**AW burst words. Each word stores its four beats independently of every other address.
- R6: A read returns the data of all writes accepted at or before the read's acceptance edge, including a write to the same address in the same cycle or whose beats are still being collected. Writes accepted after the read do not affect it.
- R7: While a port's burst is in progress (the three cycles after the acceptance edge), a request on that port is ignored and its data is not stored. A new request four cycles after the last one is accepted.
- R8: After reset, `dvalid_o` is low, `dout_o` is zero and both ports are idle.
- R9: A read and a write presented in the same cycle are both accepted, whether they target the same address or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat clock, twice the data rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read burst request |
| wr_req_i | input | 1 | Write burst request; beat 0 comes in the same cycle |
| addr_i | input | AW | Burst address shared by both ports |
| din_i | input | BYTE_W*LANES | Write data beat |
| be_i | input | LANES | Per-beat lane write enables, active high |
| oreg_sep_i | input | 1 | 1: output register on the separate output clock (one extra cycle) |
| dout_o | output | BYTE_W*LANES | Read data beat, zero when not valid |
| dvalid_o | output | 1 | Read beat valid |

## Verification
The bench builds the core with AW=4, BYTE_W=9 and LANES=4. This gives a 36-bit beat with four 9-bit lanes, so the odd lane width shows any lane misplacement in the enables. With only sixteen burst words, every address can be written and read back. Back-to-back bursts, a read in the same cycle as a write to the same address, reads that land one, two and three cycles into a write burst, requests made while a port is busy, and both output-timing modes therefore all fit in a few hundred cycles.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int BEATS  = 4;
  localparam int BEAT_W = $clog2(BEATS);
  typedef logic [BEAT_W-1:0] beat_t;
  localparam beat_t LAST_BEAT = beat_t'(BEATS - 1);
endpackage

// File: rtl/qdr_wr_demux.sv
module qdr_wr_demux
  import qdr_pkg::*;
#(
  parameter int DW    = 36,
  parameter int LANES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [DW-1:0]          din_i,
  input  logic [LANES-1:0]       be_i,
  output logic                   busy_o,
  output logic                   commit_o,
  output logic [BEATS*DW-1:0]    word_o,
  output logic [BEATS*LANES-1:0] mask_o
);
  beat_t            idx_q;
  logic             act_q;
  logic [DW-1:0]    dbuf_q [BEATS-1];
  logic [LANES-1:0] mbuf_q [BEATS-1];
  beat_t            cur_idx;

  assign cur_idx  = act_q ? idx_q : '0;
  assign busy_o   = act_q;
  assign commit_o = act_q && (idx_q == LAST_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      idx_q <= beat_t'(1);
    end else if (act_q) begin
      idx_q <= idx_q + beat_t'(1);
      if (idx_q == LAST_BEAT) act_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if ((start_i || act_q) && cur_idx != LAST_BEAT) begin
      dbuf_q[cur_idx] <= din_i;
      mbuf_q[cur_idx] <= be_i;
    end
  end

  // last beat bypasses the buffer and commits in its own cycle
  for (genvar k = 0; k < BEATS; k++) begin : g_beat
    if (k < BEATS - 1) begin : g_buf
      assign word_o[k*DW +: DW]       = dbuf_q[k];
      assign mask_o[k*LANES +: LANES] = mbuf_q[k];
    end else begin : g_live
      assign word_o[k*DW +: DW]       = din_i;
      assign mask_o[k*LANES +: LANES] = be_i;
    end
  end
endmodule

// File: rtl/qdr_array.sv
module qdr_array
  import qdr_pkg::*;
#(
  parameter int AW     = 6,
  parameter int BYTE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                          clk_i,
  input  logic                          we_i,
  input  logic [AW-1:0]                 waddr_i,
  input  logic [BEATS*BYTE_W*LANES-1:0] wdata_i,
  input  logic [BEATS*LANES-1:0]        wmask_i,
  input  logic                          re_i,
  input  logic [AW-1:0]                 raddr_i,
  output logic [BEATS*BYTE_W*LANES-1:0] rdata_o
);
  localparam int DEPTH  = 1 << AW;
  localparam int NLANES = BEATS * LANES;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[g]) mem_q[waddr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
      if (re_i) rdata_o[g*BYTE_W +: BYTE_W] <= mem_q[raddr_i];
    end
  end
endmodule

// File: rtl/qdr_rd_mux.sv
module qdr_rd_mux
  import qdr_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [BEATS*DW-1:0] word_i,
  input  logic                sep_i,
  output logic [DW-1:0]       dout_o,
  output logic                dvalid_o
);
  beat_t         idx_q;
  logic          act_q;
  logic [DW-1:0] s1_d, s2_d;
  logic          s1_v, s2_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      idx_q <= '0;
      s1_v  <= 1'b0;
      s1_d  <= '0;
      s2_v  <= 1'b0;
      s2_d  <= '0;
    end else begin
      s1_v <= act_q;
      s1_d <= act_q ? word_i[int'(idx_q)*DW +: DW] : '0;
      s2_v <= s1_v;
      s2_d <= s1_d;
      if (load_i) begin
        act_q <= 1'b1;
        idx_q <= '0;
      end else if (act_q) begin
        idx_q <= idx_q + beat_t'(1);
        if (idx_q == LAST_BEAT) act_q <= 1'b0;
      end
    end
  end

  // separate output clock modelled as one more launch stage
  assign dout_o   = sep_i ? s2_d : s1_d;
  assign dvalid_o = sep_i ? s2_v : s1_v;
endmodule

// File: rtl/qdr_b4_core.sv
module qdr_b4_core
  import qdr_pkg::*;
#(
  parameter int AW     = 6,
  parameter int BYTE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_req_i,
  input  logic                      wr_req_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [BYTE_W*LANES-1:0]   din_i,
  input  logic [LANES-1:0]          be_i,
  input  logic                      oreg_sep_i,
  output logic [BYTE_W*LANES-1:0]   dout_o,
  output logic                      dvalid_o
);
  localparam int DW = BYTE_W * LANES;
  localparam int WW = BEATS * DW;
  localparam int ML = BEATS * LANES;

  beat_t            rd_left_q;
  logic             rd_acc, wr_acc, wr_busy, wr_commit;
  logic [AW-1:0]    waddr_q;
  logic [BEATS-1:0] rv_q;
  logic [AW-1:0]    ra_q [BEATS];
  logic [WW-1:0]    wword, rword;
  logic [ML-1:0]    wmask;

  assign rd_acc = rd_req_i && (rd_left_q == '0);
  assign wr_acc = wr_req_i && !wr_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_left_q <= '0;
      rv_q      <= '0;
    end else begin
      if (rd_acc) rd_left_q <= LAST_BEAT;
      else if (rd_left_q != '0) rd_left_q <= rd_left_q - beat_t'(1);
      rv_q <= {rv_q[BEATS-2:0], rd_acc};
    end
  end

  // read fetch waits one burst so every earlier-accepted write has committed
  always_ff @(posedge clk_i) begin
    ra_q[0] <= addr_i;
    for (int k = 1; k < BEATS; k++) ra_q[k] <= ra_q[k-1];
    if (wr_acc) waddr_q <= addr_i;
  end

  qdr_wr_demux #(.DW(DW), .LANES(LANES)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wr_acc),
    .din_i    (din_i),
    .be_i     (be_i),
    .busy_o   (wr_busy),
    .commit_o (wr_commit),
    .word_o   (wword),
    .mask_o   (wmask)
  );

  qdr_array #(.AW(AW), .BYTE_W(BYTE_W), .LANES(LANES)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_commit),
    .waddr_i (waddr_q),
    .wdata_i (wword),
    .wmask_i (wmask),
    .re_i    (rv_q[BEATS-1]),
    .raddr_i (ra_q[BEATS-1]),
    .rdata_o (rword)
  );

  qdr_rd_mux #(.DW(DW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rv_q[BEATS-1]),
    .word_i   (rword),
    .sep_i    (oreg_sep_i),
    .dout_o   (dout_o),
    .dvalid_o (dvalid_o)
  );
endmodule

// File: rtl/qdr_b4_core_chk.sv
module qdr_b4_core_chk #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_req_i,
  input logic          oreg_sep_i,
  input logic [DW-1:0] dout_o,
  input logic          dvalid_o
);
  logic [1:0] rcnt_q, vrun_q;
  logic       c_acc;

  assign c_acc = rd_req_i && (rcnt_q == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q <= 2'd0;
      vrun_q <= 2'd0;
    end else begin
      if (c_acc) rcnt_q <= 2'd3;
      else if (rcnt_q != 2'd0) rcnt_q <= rcnt_q - 2'd1;
      vrun_q <= dvalid_o ? vrun_q + 2'd1 : 2'd0;
    end
  end

  // R3
  valid_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dvalid_o) |-> vrun_q == 2'd0);
  // R3
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dvalid_o |-> dout_o == '0);
  // R2
  lat_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_acc && !oreg_sep_i) |-> ##6 dvalid_o);
  // R2
  lat_sep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_acc && oreg_sep_i) |-> ##7 dvalid_o);
  // R2
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dvalid_o) && !oreg_sep_i) |-> $past(c_acc, 6));
endmodule

bind qdr_b4_core qdr_b4_core_chk #(.AW(AW), .DW(BYTE_W*LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_req_i   (rd_req_i),
  .oreg_sep_i (oreg_sep_i),
  .dout_o     (dout_o),
  .dvalid_o   (dvalid_o)
);

// File: tb/sim_qdr_b4_core.sv
`timescale 1ns/1ps
module sim_qdr_b4_core;
  localparam int AW = 4, BW = 9, LN = 4;
  localparam int DW = BW*LN, WW = 4*DW, ML = 4*LN, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0, sep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic [LN-1:0] be = '0;
  logic dvalid;

  always #2.5 clk = ~clk;

  qdr_b4_core #(.AW(AW), .BYTE_W(BW), .LANES(LN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .addr_i(addr), .din_i(din), .be_i(be), .oreg_sep_i(sep),
    .dout_o(dout), .dvalid_o(dvalid));

  int checks = 0, errors = 0, cyc = 0, lat = 5, r_left = 0, w_left = 0, wbeat = 0;
  bit mon_en = 0, done = 0;
  string cur_tag = "R1";
  logic [WW-1:0] shadow [DEPTH];
  logic [WW-1:0] wburst;
  logic [ML-1:0] wmsk;
  logic [DW-1:0] exp_d [int];
  string exp_tag [int];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic logic [WW-1:0] rnd_word();
    logic [159:0] t;
    t = {$urandom, $urandom, $urandom, $urandom, $urandom};
    return t[WW-1:0];
  endfunction

  function automatic logic [ML-1:0] rnd_mask();
    logic [31:0] t;
    t = $urandom;
    return t[ML-1:0];
  endfunction

  always @(negedge clk) begin : mon
    if (mon_en) begin
      checks++;
      if (dvalid !== exp_d.exists(cyc)) begin
        errors++;
        $display("FAIL R2/R3 dvalid cyc=%0d actual=%b expected=%b", cyc, dvalid, exp_d.exists(cyc));
      end
      checks++;
      if (exp_d.exists(cyc)) begin
        if (dout !== exp_d[cyc]) begin
          errors++;
          $display("FAIL %s data cyc=%0d actual=%h expected=%h", exp_tag[cyc], cyc, dout, exp_d[cyc]);
        end
      end else if (dout !== '0) begin
        errors++;
        $display("FAIL R3 idle data cyc=%0d actual=%h expected=0", cyc, dout);
      end
    end
  end

  // one cycle: bench-side acceptance model, shadow update, expectation
  task automatic tick(input logic rd, input logic wr, input logic [AW-1:0] a,
                      input logic [WW-1:0] wd, input logic [ML-1:0] wm);
    int t;
    t = cyc + 1;
    if (wr && w_left == 0) begin
      wburst = wd; wmsk = wm; wbeat = 0; w_left = 4;
      for (int i = 0; i < ML; i++)
        if (wm[i]) shadow[a][i*BW +: BW] = wd[i*BW +: BW];
    end
    if (rd && r_left == 0) begin
      r_left = 4;
      for (int i = 0; i < 4; i++) begin
        exp_d[t+lat+i]   = shadow[a][i*DW +: DW];
        exp_tag[t+lat+i] = cur_tag;
      end
    end
    rd_req = rd; wr_req = wr; addr = a;
    if (w_left != 0) begin
      din = wburst[wbeat*DW +: DW];
      be  = wmsk[wbeat*LN +: LN];
    end else begin
      din = '1; be = '1;
    end
    @(negedge clk);
    if (w_left != 0) begin w_left--; wbeat++; end
    if (r_left != 0) r_left--;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, '0, '0, '0);
  endtask

  task automatic t_reset;
    checks++;
    if (dvalid !== 1'b0 || dout !== '0) begin
      errors++;
      $display("FAIL R8 reset actual=%b/%h expected=0/0", dvalid, dout);
    end
  endtask

  // R5 R1 R7: fill all words back-to-back, read all back-to-back
  task automatic t_fill;
    cur_tag = "R5";
    for (int a = 0; a < DEPTH; a++) begin
      tick(0, 1, AW'(a), rnd_word(), '1);
      idle(3);
    end
    for (int a = 0; a < DEPTH; a++) begin
      tick(1, 0, AW'(a), '0, '0);
      idle(3);
    end
    idle(10);
  endtask

  // R4: partial lane writes, then read back
  task automatic t_partial;
    cur_tag = "R4";
    for (int n = 0; n < 12; n++) begin
      tick(0, 1, AW'(n), rnd_word(), rnd_mask());
      idle(3);
    end
    tick(0, 1, AW'(3), rnd_word(), '0);
    idle(3);
    for (int n = 0; n < 12; n++) begin
      tick(1, 0, AW'(n), '0, '0);
      idle(3);
    end
    idle(10);
  endtask

  // R6 R9: coherence across read/write timing offsets
  task automatic t_coherent;
    cur_tag = "R9";
    tick(1, 1, AW'(5), rnd_word(), '1);
    idle(3);
    cur_tag = "R6";
    tick(1, 0, AW'(6), '0, '0);
    tick(0, 1, AW'(6), rnd_word(), '1);
    idle(6);
    for (int off = 1; off < 4; off++) begin
      tick(0, 1, AW'(7), rnd_word(), rnd_mask());
      idle(off - 1);
      tick(1, 0, AW'(7), '0, '0);
      idle(8);
    end
    cur_tag = "R9";
    tick(1, 1, AW'(8), rnd_word(), '1);
    tick(0, 0, '0, '0, '0);
    tick(0, 0, '0, '0, '0);
    tick(0, 0, '0, '0, '0);
    tick(1, 1, AW'(9), rnd_word(), rnd_mask());
    idle(3);
    tick(1, 0, AW'(8), '0, '0);
    idle(3);
    tick(1, 0, AW'(9), '0, '0);
    idle(10);
  endtask

  // R7: requests during a burst are ignored
  task automatic t_ignore;
    cur_tag = "R7";
    tick(1, 1, AW'(10), rnd_word(), '1);
    for (int i = 0; i < 3; i++) tick(1, 1, AW'(11), rnd_word(), '1);
    tick(1, 0, AW'(11), '0, '0);
    idle(3);
    tick(1, 0, AW'(10), '0, '0);
    idle(10);
  endtask

  // R2: separate output timing adds one cycle
  task automatic t_sep;
    cur_tag = "R2";
    sep = 1'b1; lat = 6;
    idle(2);
    for (int a = 0; a < 4; a++) begin
      tick(1, 0, AW'(a), '0, '0);
      idle(3);
    end
    tick(1, 1, AW'(12), rnd_word(), rnd_mask());
    idle(10);
    sep = 1'b0; lat = 5;
    idle(2);
    tick(1, 0, AW'(12), '0, '0);
    idle(10);
  endtask

  initial begin : wdog
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    mon_en = 1;
    t_fill();
    t_partial();
    t_coherent();
    t_ignore();
    t_sep();
    mon_en = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule